// File: doc/BRIEF.md
# Software Write-Protection Command Detector

This block sits in front of a byte-wide nonvolatile array and watches every qualified write the host makes, each given as a one-cycle strobe with a 17-bit address and an 8-bit data byte. It holds a protection flag. While the flag is set, the array accepts new data only after the host sends a fixed three-write key. While the flag is clear, plain writes go straight through. A longer, six-write key that starts the same way clears the flag again.

Each write is classified in the cycle it is sampled. The result comes out one cycle later as one of three registered pulses. `wr_permit` forwards the byte to the array. `prog_req` starts an internal programming cycle. `seq_err` reports a broken key sequence. Once a programming cycle has been requested, the block waits for `prog_done` from the array side. At that edge it commits any change of the protection flag. The flag stands in for nonvolatile state: its value after reset is a parameter.

After the protect key, a page-load window opens. It closes either when a page of bytes has been loaded or when the host stays silent for a set number of cycles. The byte that fills the page and the silent cycle that ends the wait both close the window in that same cycle.

Top module: `wpcmd_guard`

## Requirements
- R1: Reset drives `prot_flag` to the parameter `PROT_INIT` and holds `wr_permit`, `prog_req` and `seq_err` low.
- R2: With `prot_flag` low, in the idle phase, a write that is not AA@5555 gives `wr_permit` and `prog_req` together. The flag is unchanged after the following `prog_done`.
- R3: With `prot_flag` high, in the idle phase, a write that is not AA@5555 is discarded. No `wr_permit`, no `prog_req` and no `seq_err` follow, and the next write is judged afresh.
- R4: The protect key is three writes: data AA to address 5555h, then 55 to 2AAAh, then A0 to 5555h. Only address bits 14:0 are compared, so bits 16:15 are ignored. Key writes never raise `wr_permit`, and the third write opens the page-load window.
- R5: In the page-load window every write raises `wr_permit`. The window closes on the `LOAD_TIMEOUT`-th consecutive cycle without a write, and that cycle raises `prog_req` one cycle later.
- R6: The write that brings the loaded count to `PAGE_BYTES` raises `wr_permit` and `prog_req` in the same cycle and closes the window.
- R7: After the protect key, `prot_flag` becomes 1 at the `prog_done` that ends the programming cycle, even when no byte was loaded.
- R8: The disable key is AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555. Its sixth write raises `prog_req`, and `prot_flag` becomes 0 at the next `prog_done`. The two keys share their first two writes and split on the third write's data.
- R9: A write that does not match the expected key step raises `seq_err` and is discarded, with no `wr_permit` and no `prog_req`. The matcher returns to idle and `prot_flag` keeps its value.
- R10: While a programming cycle is pending, writes are discarded with no output pulse. `prog_done` has no effect outside that wait.
- R11: `wr_permit`, `prog_req` and `seq_err` are registered pulses one cycle wide, seen in the cycle after the write or timeout that caused them. `prog_req` and `seq_err` never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle strobe for a qualified byte write |
| wr_addr | input | 17 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| prog_done | input | 1 | End of the array's programming cycle |
| prot_flag | output | 1 | Protection state |
| wr_permit | output | 1 | Forward this write to the array |
| prog_req | output | 1 | Start a programming cycle |
| seq_err | output | 1 | Key sequence broken by this write |

## Verification
The bench builds the block with `LOAD_TIMEOUT` = 8 and `PAGE_BYTES` = 4. These short values make both ways of closing the window reachable within a few dozen cycles: a page filled exactly, and a silent wait that ends with nothing loaded. The bench keeps the full 17-bit address and the default compare width of 15 bits. Key writes with bits 16:15 set therefore show that only the low bits are matched. Aborts are placed after the first shared step and again deep inside the disable key, which checks the fork on the third write.

// File: rtl/wpcmd_pkg.sv
package wpcmd_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_KEY1,
      PH_KEY2,
      PH_LOAD,
      PH_ERA3,
      PH_ERA4,
      PH_ERA5,
      PH_BUSY
   } phase_t;

   localparam logic [7:0]  KEY_A    = 8'hAA;
   localparam logic [7:0]  KEY_B    = 8'h55;
   localparam logic [7:0]  OP_PROT  = 8'hA0;
   localparam logic [7:0]  OP_ERASE = 8'h80;
   localparam logic [7:0]  OP_UNLK  = 8'h20;
   localparam logic [14:0] LOC_HI   = 15'h5555;
   localparam logic [14:0] LOC_LO   = 15'h2AAA;

endpackage

// File: rtl/wpcmd_decode.sv
module wpcmd_decode
   import wpcmd_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int CMP_W  = 15
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              key_a_o,
   output logic              key_b_o,
   output logic              op_prot_o,
   output logic              op_erase_o,
   output logic              op_unlk_o
);

   localparam logic [CMP_W-1:0] CMP_HI = CMP_W'(LOC_HI);
   localparam logic [CMP_W-1:0] CMP_LO = CMP_W'(LOC_LO);

   initial begin
      assert (DATA_W == 8) else $error("wpcmd_decode: DATA_W must be 8");
      assert (CMP_W >= 15 && CMP_W <= ADDR_W) else $error("wpcmd_decode: CMP_W out of range");
   end

   logic [CMP_W-1:0] cmp_addr;

   generate
      if (CMP_W == ADDR_W) begin : g_full
         assign cmp_addr = addr_i;
      end else begin : g_low
         logic unused_hi;
         assign cmp_addr  = addr_i[CMP_W-1:0];
         assign unused_hi = ^addr_i[ADDR_W-1:CMP_W];
      end
   endgenerate

   logic at_hi, at_lo;
   assign at_hi = (cmp_addr == CMP_HI);
   assign at_lo = (cmp_addr == CMP_LO);

   assign key_a_o    = at_hi && (data_i == KEY_A);
   assign key_b_o    = at_lo && (data_i == KEY_B);
   assign op_prot_o  = at_hi && (data_i == OP_PROT);
   assign op_erase_o = at_hi && (data_i == OP_ERASE);
   assign op_unlk_o  = at_hi && (data_i == OP_UNLK);

endmodule

// File: rtl/wpcmd_window.sv
module wpcmd_window #(
   parameter int LOAD_TIMEOUT = 7500,
   parameter int PAGE_BYTES   = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic active_i,
   input  logic wr_i,
   output logic close_o
);

   localparam int IDLE_W = $clog2(LOAD_TIMEOUT + 1);
   localparam int BYTE_W = $clog2(PAGE_BYTES + 1);

   initial begin
      assert (LOAD_TIMEOUT >= 1) else $error("wpcmd_window: LOAD_TIMEOUT must be positive");
      assert (PAGE_BYTES >= 1) else $error("wpcmd_window: PAGE_BYTES must be positive");
   end

   logic [IDLE_W-1:0] idle_q;
   logic [BYTE_W-1:0] bytes_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q  <= '0;
         bytes_q <= '0;
      end else if (open_i) begin
         idle_q  <= '0;
         bytes_q <= '0;
      end else if (active_i) begin
         if (wr_i) begin
            idle_q  <= '0;
            bytes_q <= bytes_q + BYTE_W'(1);
         end else begin
            idle_q  <= idle_q + IDLE_W'(1);
         end
      end
   end

   assign close_o = active_i &&
                    ((wr_i && (bytes_q == BYTE_W'(PAGE_BYTES - 1))) ||
                     (!wr_i && (idle_q == IDLE_W'(LOAD_TIMEOUT - 1))));

   // page count never passes the page size
   assert_page_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bytes_q <= BYTE_W'(PAGE_BYTES));

   // silent-cycle count never passes the timeout
   assert_idle_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      idle_q <= IDLE_W'(LOAD_TIMEOUT));

endmodule

// File: rtl/wpcmd_guard.sv
module wpcmd_guard
   import wpcmd_pkg::*;
#(
   parameter int ADDR_W       = 17,
   parameter int DATA_W       = 8,
   parameter int CMP_W        = 15,
   parameter int LOAD_TIMEOUT = 7500,
   parameter int PAGE_BYTES   = 128,
   parameter bit PROT_INIT    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              prog_done,
   output logic              prot_flag,
   output logic              wr_permit,
   output logic              prog_req,
   output logic              seq_err
);

   logic key_a, key_b, op_prot, op_erase, op_unlk;

   wpcmd_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CMP_W  (CMP_W)
   ) u_decode (
      .addr_i     (wr_addr),
      .data_i     (wr_data),
      .key_a_o    (key_a),
      .key_b_o    (key_b),
      .op_prot_o  (op_prot),
      .op_erase_o (op_erase),
      .op_unlk_o  (op_unlk)
   );

   phase_t ph_q, ph_n;
   logic   prot_q, prot_n;
   logic   tgt_q, tgt_n;
   logic   perm_q, perm_n;
   logic   req_q, req_n;
   logic   err_q, err_n;
   logic   win_open, win_close;

   wpcmd_window #(
      .LOAD_TIMEOUT (LOAD_TIMEOUT),
      .PAGE_BYTES   (PAGE_BYTES)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_i   (win_open),
      .active_i (ph_q == PH_LOAD),
      .wr_i     (wr_stb),
      .close_o  (win_close)
   );

   always_comb begin
      ph_n     = ph_q;
      prot_n   = prot_q;
      tgt_n    = tgt_q;
      perm_n   = 1'b0;
      req_n    = 1'b0;
      err_n    = 1'b0;
      win_open = 1'b0;
      unique case (ph_q)
         PH_IDLE: if (wr_stb) begin
            if (key_a) begin
               ph_n = PH_KEY1;
            end else if (!prot_q) begin
               perm_n = 1'b1;
               req_n  = 1'b1;
               tgt_n  = prot_q;
               ph_n   = PH_BUSY;
            end
         end
         PH_KEY1: if (wr_stb) begin
            if (key_b) ph_n = PH_KEY2;
            else begin err_n = 1'b1; ph_n = PH_IDLE; end
         end
         PH_KEY2: if (wr_stb) begin
            if (op_prot) begin
               ph_n     = PH_LOAD;
               win_open = 1'b1;
            end else if (op_erase) begin
               ph_n = PH_ERA3;
            end else begin
               err_n = 1'b1;
               ph_n  = PH_IDLE;
            end
         end
         PH_LOAD: begin
            perm_n = wr_stb;
            if (win_close) begin
               req_n = 1'b1;
               tgt_n = 1'b1;
               ph_n  = PH_BUSY;
            end
         end
         PH_ERA3: if (wr_stb) begin
            if (key_a) ph_n = PH_ERA4;
            else begin err_n = 1'b1; ph_n = PH_IDLE; end
         end
         PH_ERA4: if (wr_stb) begin
            if (key_b) ph_n = PH_ERA5;
            else begin err_n = 1'b1; ph_n = PH_IDLE; end
         end
         PH_ERA5: if (wr_stb) begin
            if (op_unlk) begin
               req_n = 1'b1;
               tgt_n = 1'b0;
               ph_n  = PH_BUSY;
            end else begin
               err_n = 1'b1;
               ph_n  = PH_IDLE;
            end
         end
         PH_BUSY: if (prog_done) begin
            prot_n = tgt_q;
            ph_n   = PH_IDLE;
         end
         default: ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         prot_q <= PROT_INIT;
         tgt_q  <= PROT_INIT;
         perm_q <= 1'b0;
         req_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         ph_q   <= ph_n;
         prot_q <= prot_n;
         tgt_q  <= tgt_n;
         perm_q <= perm_n;
         req_q  <= req_n;
         err_q  <= err_n;
      end
   end

   assign prot_flag = prot_q;
   assign wr_permit = perm_q;
   assign prog_req  = req_q;
   assign seq_err   = err_q;

   // a forwarded byte always traces back to a sampled write
   assert_permit_from_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_permit |-> $past(wr_stb));

   // an abort always traces back to a sampled write
   assert_err_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |-> $past(wr_stb));

   // the flag only moves at the end of a programming cycle
   assert_flag_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_q != $past(prot_q)) |-> $past(prog_done));

   // a write forwarded while protected must come from the load window
   assert_locked_permit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_permit && prot_flag) |-> ($past(ph_q) == PH_LOAD));

   // programming request is a single-cycle pulse
   assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> !prog_req);

   // no request and abort at once
   assert_req_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_req && seq_err));

endmodule

// File: tb/wpcmd_guard_bench.sv
module wpcmd_guard_bench;

   localparam int TMO = 8;
   localparam int PG  = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_stb;
   logic [16:0] wr_addr;
   logic [7:0]  wr_data;
   logic        prog_done;
   logic        prot_flag, wr_permit, prog_req, seq_err;

   always #10 clk = ~clk;

   wpcmd_guard #(
      .LOAD_TIMEOUT (TMO),
      .PAGE_BYTES   (PG),
      .PROT_INIT    (1'b0)
   ) u_wpcmd_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .prog_done (prog_done),
      .prot_flag (prot_flag),
      .wr_permit (wr_permit),
      .prog_req  (prog_req),
      .seq_err   (seq_err)
   );

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   // behavioural reference
   localparam int M_IDLE = 0, M_K1 = 1, M_K2 = 2, M_LOAD = 3,
                  M_E3 = 4, M_E4 = 5, M_E5 = 6, M_WAIT = 7;
   int  m_phase;
   bit  m_prot, m_tgt;
   int  m_quiet;
   byte m_page[$];
   bit  e_perm, e_req, e_err;

   function automatic bit at5(logic [16:0] a);
      return a[14:0] == 15'h5555;
   endfunction
   function automatic bit at2(logic [16:0] a);
      return a[14:0] == 15'h2AAA;
   endfunction

   task automatic model(bit s, logic [16:0] a, logic [7:0] d, bit dn);
      e_perm = 0; e_req = 0; e_err = 0;
      case (m_phase)
         M_IDLE: if (s) begin
            if (at5(a) && d == 8'hAA) m_phase = M_K1;
            else if (!m_prot) begin
               e_perm = 1; e_req = 1; m_tgt = m_prot; m_phase = M_WAIT;
            end
         end
         M_K1: if (s) begin
            if (at2(a) && d == 8'h55) m_phase = M_K2;
            else begin e_err = 1; m_phase = M_IDLE; end
         end
         M_K2: if (s) begin
            if (at5(a) && d == 8'hA0) begin
               m_phase = M_LOAD; m_page.delete(); m_quiet = 0;
            end else if (at5(a) && d == 8'h80) m_phase = M_E3;
            else begin e_err = 1; m_phase = M_IDLE; end
         end
         M_LOAD: begin
            if (s) begin
               e_perm = 1; m_page.push_back(d); m_quiet = 0;
               if (m_page.size() == PG) begin e_req = 1; m_tgt = 1; m_phase = M_WAIT; end
            end else begin
               m_quiet++;
               if (m_quiet == TMO) begin e_req = 1; m_tgt = 1; m_phase = M_WAIT; end
            end
         end
         M_E3: if (s) begin
            if (at5(a) && d == 8'hAA) m_phase = M_E4;
            else begin e_err = 1; m_phase = M_IDLE; end
         end
         M_E4: if (s) begin
            if (at2(a) && d == 8'h55) m_phase = M_E5;
            else begin e_err = 1; m_phase = M_IDLE; end
         end
         M_E5: if (s) begin
            if (at5(a) && d == 8'h20) begin e_req = 1; m_tgt = 0; m_phase = M_WAIT; end
            else begin e_err = 1; m_phase = M_IDLE; end
         end
         default: if (dn) begin m_prot = m_tgt; m_phase = M_IDLE; end
      endcase
   endtask

   task automatic compare(string tag);
      logic [3:0] act, exp;
      act = {prot_flag, wr_permit, prog_req, seq_err};
      exp = {m_prot, e_perm, e_req, e_err};
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {prot,permit,req,err} actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(bit s, logic [16:0] a, logic [7:0] d, bit dn, string tag);
      wr_stb = s; wr_addr = a; wr_data = d; prog_done = dn;
      model(s, a, d, dn);
      @(posedge clk);
      @(negedge clk);
      wr_stb = 0; prog_done = 0;
      compare(tag);
   endtask

   task automatic wr(logic [16:0] a, logic [7:0] d, string tag);
      step(1, a, d, 0, tag);
   endtask

   task automatic quiet(int n, string tag);
      for (int i = 0; i < n; i++) step(0, '0, '0, 0, tag);
   endtask

   task automatic finish_prog(string tag);
      step(0, '0, '0, 1, tag);
   endtask

   task automatic prot_key(string tag);
      wr(17'h05555, 8'hAA, tag);
      wr(17'h02AAA, 8'h55, tag);
      wr(17'h05555, 8'hA0, tag);
   endtask

   initial begin
      wr_stb = 0; wr_addr = '0; wr_data = '0; prog_done = 0; rst_n = 0;
      m_phase = M_IDLE; m_prot = 0; m_tgt = 0; m_quiet = 0;
      e_perm = 0; e_req = 0; e_err = 0;
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1;
      quiet(2, "R1 after reset");

      // unprotected plain write, then a write during the pending cycle
      wr(17'h00123, 8'h3C, "R2 plain write");
      wr(17'h00124, 8'h11, "R10 write while busy");
      quiet(2, "R10 waiting");
      finish_prog("R2 done keeps flag");
      step(0, '0, '0, 1, "R10 stray done ignored");

      // protect key with bit 16:15 set on first step, two bytes, then timeout
      wr(17'h1D555, 8'hAA, "R4 key step1 high bits");
      wr(17'h02AAA, 8'h55, "R4 key step2");
      wr(17'h05555, 8'hA0, "R4 key step3");
      wr(17'h00200, 8'h01, "R5 load byte");
      wr(17'h00201, 8'h02, "R5 load byte");
      quiet(TMO, "R5 timeout close");
      quiet(1, "R5 waiting");
      finish_prog("R7 flag set");

      // protected: plain write discarded
      wr(17'h00300, 8'h77, "R3 locked write dropped");
      wr(17'h00301, 8'h78, "R3 locked write dropped again");

      // abort after first step
      wr(17'h05555, 8'hAA, "R9 abort setup");
      wr(17'h02AAB, 8'h55, "R9 wrong address aborts");
      wr(17'h00302, 8'h79, "R3 still locked after abort");

      // full page closes window
      prot_key("R4 key again");
      for (int i = 0; i < PG; i++) wr(17'(17'h00400 + i), 8'(8'h40 + i), "R6 page fill");
      quiet(1, "R6 waiting");
      finish_prog("R7 flag stays set");

      // key with no data bytes
      prot_key("R4 empty load key");
      quiet(TMO, "R7 empty window timeout");
      finish_prog("R7 set with zero bytes");

      // disable key aborted at step 5
      wr(17'h05555, 8'hAA, "R8 disable s1");
      wr(17'h02AAA, 8'h55, "R8 disable s2");
      wr(17'h05555, 8'h80, "R8 disable s3 fork");
      wr(17'h05555, 8'hAA, "R8 disable s4");
      wr(17'h02AAA, 8'h56, "R9 disable s5 wrong data");
      wr(17'h00500, 8'h05, "R9 flag kept after abort");

      // full disable key
      wr(17'h05555, 8'hAA, "R8 disable s1");
      wr(17'h02AAA, 8'h55, "R8 disable s2");
      wr(17'h05555, 8'h80, "R8 disable s3");
      wr(17'h05555, 8'hAA, "R8 disable s4");
      wr(17'h02AAA, 8'h55, "R8 disable s5");
      wr(17'h05555, 8'h20, "R8 disable s6 request");
      wr(17'h00600, 8'h06, "R10 busy write dropped");
      finish_prog("R8 flag cleared");
      wr(17'h00601, 8'h07, "R2 plain write after unlock");
      finish_prog("R11 single pulses");
      quiet(2, "R11 idle");

      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog R11: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule